// File: doc/BRIEF.md
# Handshaked Variable-Latency ALU

A 16-bit arithmetic unit with a valid/ready handshake on its operand side and another on its result side. Each accepted request carries two operands, a two-bit operation select and a flag that bitwise-complements operand A before use. The unit returns exactly one result word per accepted request, truncated to 16 bits.

Operations differ in cost. Add and logical shift right produce their result one cycle after acceptance. Low-half multiply runs through a short internal pipeline and takes three cycles. The difference operation (A minus B) adds no latency. When the unit is idle, its result is offered combinationally in the same cycle as the request. Only one request is in flight at a time, so results leave strictly in acceptance order. The producer and the consumer may each stall or stream back-to-back without coordinating with each other.

Top module: `hs_alu`

## Requirements
- R1: While rst_n is low at a clock edge, the unit returns to idle. After that edge in_ready is 1 and out_valid is 0.
- R2: Select 2'b00 returns (A' + B) mod 2^16, where A' is the possibly complemented operand A. out_valid is first high in the cycle after the accepting edge.
- R3: When inv_a is 1, A' is the ones complement of opa with no +1 added. For example, inverted 5 plus 3 gives 65533.
- R4: Select 2'b01 returns the low 16 bits of A' * B. out_valid is low in the first and second cycles after the accepting edge and high in the third.
- R5: Select 2'b10 returns A' shifted right logically by the value of the low 4 bits of opb. The upper bits of opb are ignored.
- R6: Select 2'b11 returns (A' - B) mod 2^16. When the unit is idle, out_valid and the result appear in the same cycle that in_valid is presented.
- R7: in_ready is 0 while a multiply is in progress. It is also 0 while a result is pending and out_ready is low.
- R8: Every accepted request yields exactly one result, and results leave in acceptance order under any stall pattern on either side.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged on the next cycle.
- R10: When in_valid and out_ready are both held high, one-cycle operations are accepted on consecutive cycles with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a request |
| in_ready | output | 1 | Unit can take a request this cycle |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| opsel | input | 2 | 00 add, 01 multiply low, 10 shift right logical, 11 difference |
| inv_a | input | 1 | Complement operand A before use |
| out_valid | output | 1 | Result word is offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Result word |

## Verification
A wrong sequencing state shows up at the ports within one or two cycles. It appears as a result offered too early or too late, as in_ready high while a multiply is still running, or as a result that is dropped, repeated or reordered against the request stream. The scoreboard catches a dropped, repeated or reordered result on the next result the consumer accepts. Directed cycle counts catch a latency error on the exact cycle where it occurs. A corrupted held result is seen on the first stalled cycle, because the stalled data must stay stable.

// File: rtl/hs_alu_pkg.sv
// Shared types for the handshaked ALU.
// Assumes a two-bit operation select whose encoding the datapath decodes.
package hs_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_MUL  = 2'b01,
        OP_SHR  = 2'b10,
        OP_DIFF = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01,
        ST_HOLD = 2'b10
    } seq_st_e;

endpackage

// File: rtl/hs_alu_exec.sv
// Single-cycle combinational datapath: operand conditioning plus add,
// logical right shift and difference. The multiply is handled elsewhere.
// Assumes SHW = clog2(W) so the shift count covers exactly 0..W-1.
module hs_alu_exec
    import hs_alu_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         inv,
    output logic [W-1:0] a_eff,
    output logic [W-1:0] res
);

    // conditional ones complement of operand A
    always_comb a_eff = inv ? ~a : a;

    // select the single-cycle result; multiply yields zero here
    always_comb begin
        unique case (op)
            OP_ADD:  res = a_eff + b;
            OP_SHR:  res = a_eff >> b[SHW-1:0];
            OP_DIFF: res = a_eff - b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/hs_alu_mul.sv
// Fixed-latency low-half multiplier built as a chain of NST registered
// stages. The product is formed at start and walks the chain.
// Assumes at most one operation is started per chain traversal (the
// sequencer guarantees it) and LAT >= 2.
module hs_alu_mul #(
    parameter int W   = 16,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         done,
    output logic [W-1:0] prod
);

    localparam int NST = LAT - 1;

    logic [W-1:0] p_low;
    logic [NST-1:0] sv;
    logic [W-1:0] sd [NST];

    // truncated product of the two operands
    always_comb p_low = a * b;

    for (genvar i = 0; i < NST; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first stage captures the fresh product
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sv[0] <= 1'b0;
                end else begin
                    sv[0] <= start;
                end
                if (start) sd[0] <= p_low;
            end
        end else begin : g_next
            // later stages pass the token and data along
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sv[i] <= 1'b0;
                end else begin
                    sv[i] <= sv[i-1];
                end
                sd[i] <= sd[i-1];
            end
        end
    end

    assign done = sv[NST-1];
    assign prod = sd[NST-1];

    // R8: never more than one multiply in flight
    p_one_token_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sv));

endmodule

// File: rtl/hs_alu.sv
// Handshaked variable-latency ALU top. A three-state sequencer admits one
// request at a time, so result order equals acceptance order. Add and
// shift land in the hold register one edge after acceptance. Multiply
// lands after the multiplier chain. Difference bypasses straight to the
// output when the unit is idle.
// Assumes MUL_LAT >= 2 and a consumer that obeys valid/ready.
module hs_alu
    import hs_alu_pkg::*;
#(
    parameter int W       = 16,
    parameter int MUL_LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   opsel,
    input  logic         inv_a,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    localparam int SHW = $clog2(W);

    alu_op_e       op;
    seq_st_e       st;
    logic [W-1:0]  hold_d;
    logic [W-1:0]  a_eff;
    logic [W-1:0]  x_res;
    logic          acc;
    logic          bypass;
    logic          m_done;
    logic [W-1:0]  m_prod;

    assign op = alu_op_e'(opsel);

    hs_alu_exec #(.W(W), .SHW(SHW)) exec_i (
        .a     (opa),
        .b     (opb),
        .op    (op),
        .inv   (inv_a),
        .a_eff (a_eff),
        .res   (x_res)
    );

    hs_alu_mul #(.W(W), .LAT(MUL_LAT)) mul_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acc && op == OP_MUL),
        .a     (a_eff),
        .b     (opb),
        .done  (m_done),
        .prod  (m_prod)
    );

    // take a request when idle, or when the held result leaves this cycle
    always_comb in_ready = (st == ST_IDLE) || (st == ST_HOLD && out_ready);

    // handshake and zero-latency bypass detection
    always_comb begin
        acc    = in_valid && in_ready;
        bypass = (st == ST_IDLE) && in_valid && (op == OP_DIFF);
    end

    // result port: held value, else the bypassed difference
    always_comb begin
        out_valid = (st == ST_HOLD) || bypass;
        out_data  = (st == ST_HOLD) ? hold_d : x_res;
    end

    // sequencer: track the single in-flight request and capture its result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else if (acc) begin
            if (op == OP_MUL) begin
                st <= ST_BUSY;
            end else if (bypass && out_ready) begin
                st <= ST_IDLE;
            end else begin
                st     <= ST_HOLD;
                hold_d <= x_res;
            end
        end else if (st == ST_HOLD && out_ready) begin
            st <= ST_IDLE;
        end else if (st == ST_BUSY && m_done) begin
            st     <= ST_HOLD;
            hold_d <= m_prod;
        end
    end

    // R9: a stalled result keeps its valid and its value
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: no new request while the multiplier runs
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |-> !in_ready);

    // R4: multiply result is not offered on the first cycle after acceptance
    p_mul_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == OP_MUL) |=> !out_valid);

    // R2: add and shift are offered one cycle after acceptance
    p_fast_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (op == OP_ADD || op == OP_SHR)) |=> out_valid);

    // R6: a difference taken while idle is offered in the same cycle
    p_diff_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == OP_DIFF && $past(out_valid) == 1'b0 && !$past(st == ST_BUSY))
        |-> out_valid);

endmodule

// File: tb/hs_alu_tb_top.sv
module hs_alu_tb_top;

    localparam int CLK_PER = 10;
    localparam int W       = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [1:0]   opsel = 2'b00;
    logic         inv_a = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int last_acc_cyc = 0;
    logic last_ov = 1'b0;
    logic done_flag = 1'b0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    hs_alu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .opa       (opa),
        .opb       (opb),
        .opsel     (opsel),
        .inv_a     (inv_a),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // expected value from the requirement text
    function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [1:0] s, logic inv);
        logic [W-1:0] ae;
        ae = inv ? ~a : a;
        case (s)
            2'b00: return ae + b;
            2'b01: return ae * b;
            2'b10: return ae >> b[3:0];
            default: return ae - b;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: present a request, wait for acceptance, queue the expectation
    task automatic send(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] s, logic inv);
        string t;
        opa = a; opb = b; opsel = s; inv_a = inv; in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        t = inv ? "R3" : (s == 2'b00) ? "R2" : (s == 2'b01) ? "R4" :
            (s == 2'b10) ? "R5" : "R6";
        exp_q.push_back(model(a, b, s, inv));
        tag_q.push_back(t);
        last_ov = out_valid;
        last_acc_cyc = cyc;
        @(negedge clk);
        in_valid = 1'b0; opa = '0; opb = '0; inv_a = 1'b0;
    endtask

    // consumer ready pattern
    always @(negedge clk) begin
        case (rdy_mode)
            0: out_ready <= 1'b1;
            1: out_ready <= (cyc % 3) != 2;
            default: out_ready <= cyc[2] ^ cyc[0];
        endcase
    end

    // monitor: scoreboard compare on each consumed result, stall stability
    logic         stalled = 1'b0;
    logic [W-1:0] stall_d = '0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (stalled) begin
                check("R9 valid", {31'd0, out_valid}, 32'd1);
                check("R9 data", {16'd0, out_data}, {16'd0, stall_d});
            end
            stalled = out_valid && !out_ready;
            stall_d = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R8 actual=%0h expected=none", out_data);
                end else begin
                    check({"R8 ", tag_q.pop_front()}, {16'd0, out_data},
                          {16'd0, exp_q.pop_front()});
                end
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);

        // mixed sequence with consumer stalls
        rdy_mode = 1;
        send(16'd5, 16'd3, 2'b00, 1'b0);
        @(negedge clk);
        send(16'd2, 16'd3, 2'b01, 1'b0);
        send(16'd5, 16'd3, 2'b00, 1'b1);
        send(16'd5, 16'd3, 2'b11, 1'b0);
        send(16'd13, 16'd2, 2'b10, 1'b0);
        drain();

        // latency checks, consumer always ready
        rdy_mode = 0;
        @(negedge clk);
        send(16'h1234, 16'h0100, 2'b01, 1'b0);
        #1;
        check("R4 cycle1 valid", {31'd0, out_valid}, 32'd0);
        check("R7 cycle1 ready", {31'd0, in_ready}, 32'd0);
        @(negedge clk); #1;
        check("R4 cycle2 valid", {31'd0, out_valid}, 32'd0);
        check("R7 cycle2 ready", {31'd0, in_ready}, 32'd0);
        @(negedge clk); #1;
        check("R4 cycle3 valid", {31'd0, out_valid}, 32'd1);
        drain();
        send(16'hFFFF, 16'd2, 2'b00, 1'b0);
        #1;
        check("R2 cycle1 valid", {31'd0, out_valid}, 32'd1);
        drain();
        send(16'd3, 16'd5, 2'b11, 1'b0);
        check("R6 same-cycle valid", {31'd0, last_ov}, 32'd1);
        drain();
        send(16'h0000, 16'd1, 2'b11, 1'b1);
        send(16'h8000, 16'h0013, 2'b10, 1'b0);
        send(16'hFFF0, 16'h0004, 2'b10, 1'b1);
        drain();

        // R7: consumer stalled with a held result blocks new requests
        rdy_mode = 3;
        out_ready <= 1'b0;
        @(negedge clk);
        rdy_mode = 4;
        fork
            send(16'd1, 16'd1, 2'b00, 1'b0);
        join_none
        @(negedge clk);
        out_ready <= 1'b0;
        @(negedge clk); #1;
        check("R7 held ready", {31'd0, in_ready}, 32'd0);
        rdy_mode = 0;
        drain();

        // R10: back-to-back single-cycle requests
        begin
            int prev;
            send(16'd1, 16'd2, 2'b00, 1'b0);
            prev = last_acc_cyc;
            for (int k = 0; k < 3; k++) begin
                send(16'(k), 16'd1, 2'b10, 1'b0);
                check("R10 gap", 32'(last_acc_cyc - prev), 32'd1);
                prev = last_acc_cyc;
            end
        end
        drain();

        // R8: long mixed stream with irregular stalls
        rdy_mode = 2;
        for (int k = 0; k < 24; k++) begin
            send(16'(k * 977 + 11), 16'(k * 31 + 2), 2'(k % 4), k[2]);
            if (k % 5 == 0) @(negedge clk);
        end
        drain();
        finish_run();
    end

    // hold out_ready low in the manual stall modes
    always @(negedge clk) begin
        if (rdy_mode >= 3) out_ready <= 1'b0;
    end

endmodule